// File: doc/BRIEF.md
# Ethernet Receive Framer and Stripper

This block is the first stage of an Ethernet receiver. It takes one byte per clock from a media-independent byte interface, qualified by a data-valid strobe. It recognises the preamble and the start-of-frame delimiter and drops both. It then forwards the frame from the destination address onward as a byte stream, and marks the last forwarded byte. One cycle after the frame ends it presents a status word. The status word carries a CRC error flag, a watchdog-cut flag, a truncation flag, the number of bytes received and, when enabled, a copy of the system time sampled when the delimiter arrived.

When stripping is enabled and the length/type field holds a length below 0x600, only the header and the stated number of data bytes are forwarded. Padding and FCS are still received and still enter the CRC check, but they are not passed on. Type values and disabled stripping forward every byte. Two length limits protect the receiver. A configurable watchdog cutoff applies when the watchdog is on, and a larger hard cutoff always applies. A frame reaching either limit is ended at once and flagged.

The control is a four-state machine. IDLE waits for traffic. PREAMBLE consumes 0x55 bytes. BODY counts, checks and forwards frame bytes. DISCARD ignores the rest of a burst that cannot be a frame. The transitions are as follows:
- IDLE→PREAMBLE on 0x55.
- IDLE→BODY and PREAMBLE→BODY on the delimiter 0xD5.
- IDLE→DISCARD and PREAMBLE→DISCARD on any other valid byte.
- PREAMBLE→IDLE when valid drops.
- BODY→IDLE (frame end) when valid drops.
- BODY→DISCARD (watchdog cut) when a byte arrives with the limit already reached.
- DISCARD→IDLE when valid drops.

Top module: `eth_rx_framer`

## Requirements
- R1: Zero or more 0x55 bytes followed by 0xD5 start a frame, and the first byte forwarded is the one after 0xD5. A valid byte other than 0x55 or 0xD5 seen before the delimiter makes the whole burst ignored, with no output and no status.
- R2: Forwarded bytes leave in arrival order, one cycle or more after they arrive. The last forwarded byte of a frame has out_last set in the same cycle as the single stat_valid pulse. That pulse comes one cycle after the frame ends.
- R3: The length/type value is bytes 12 (high) and 13 (low) after the delimiter. With cfg_strip_en set and a value L below 0x600, exactly the first 14+L received bytes are forwarded, or fewer if fewer arrive.
- R4: With cfg_strip_en clear, or with a length/type value of 0x600 or more, every accepted byte is forwarded, FCS included.
- R5: With cfg_wdog_en set, a frame byte arriving after WDOG_LIMIT bytes is not forwarded. That byte ends the frame with stat_wdog set and stat_len equal to WDOG_LIMIT, and the rest of the burst is ignored.
- R6: With cfg_wdog_en clear, the same cut happens at HARD_LIMIT bytes, with stat_wdog set and stat_len equal to HARD_LIMIT.
- R7: stat_crc_err is clear exactly when the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones) run over all accepted bytes leaves the residue 0xDEBB20E3. This holds whether or not stripping is enabled.
- R8: At the delimiter, stat_ts_valid takes the value of cfg_ts_en, and stat_ts takes sys_time if timestamping is enabled. Both hold until the next delimiter.
- R9: stat_len is the number of accepted bytes from the destination address through the FCS. stat_trunc is set when valid drops with fewer than 18 bytes accepted.
- R10: A burst of only preamble bytes that ends before any delimiter produces no output and no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_dv | input | 1 | Byte valid from the media interface |
| rx_data | input | 8 | Received byte |
| cfg_strip_en | input | 1 | Enable pad/FCS removal for length-coded frames |
| cfg_wdog_en | input | 1 | Select the configurable cutoff (set) or the hard cutoff (clear) |
| cfg_ts_en | input | 1 | Enable timestamp capture at the delimiter |
| sys_time | input | TS_W | Free-running system time |
| out_valid | output | 1 | Forwarded byte present |
| out_data | output | 8 | Forwarded byte |
| out_last | output | 1 | Marks the final forwarded byte of a frame |
| stat_valid | output | 1 | One-cycle status strobe per frame |
| stat_crc_err | output | 1 | CRC residue mismatch |
| stat_wdog | output | 1 | Frame was cut by a length limit |
| stat_trunc | output | 1 | Frame ended before 18 bytes |
| stat_len | output | LEN_W | Accepted byte count |
| stat_ts_valid | output | 1 | Timestamp captured for this frame |
| stat_ts | output | TS_W | Captured system time |

## Verification
The bench sweeps the length field across every value around the 46-byte minimum with stripping on and off. An off-by-one in the keep count would forward one pad byte too many or drop the last data byte, and a design that ignores the type threshold would clip frames that carry a type. Frame lengths are stepped across both cutoffs. A limit compared with the wrong relation cuts one byte early or lets one extra byte through, and both show up in stat_len and in the forwarded count. Short bursts from zero to twenty bytes check the truncation boundary at 18. Bad preamble bytes and preamble-only bursts check that a design without a discard path does not emit spurious frames or status.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_BODY,
        ST_DISCARD
    } rx_state_t;

    typedef struct packed {
        logic crc_err;
        logic wdog;
        logic trunc;
    } rx_flags_t;

    localparam logic [7:0]  PRE_BYTE        = 8'h55;
    localparam logic [7:0]  SFD_BYTE        = 8'hD5;
    localparam logic [31:0] CRC_POLY        = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT        = 32'hFFFFFFFF;
    localparam logic [31:0] CRC_RESIDUE     = 32'hDEBB20E3;
    localparam logic [15:0] TYPE_THRESHOLD  = 16'h0600;
    localparam int          HDR_BYTES       = 14;
    localparam int          LT_HI_IDX       = 12;
    localparam int          LT_LO_IDX       = 13;
    localparam int          MIN_FRAME_BYTES = 18;

    // One byte through the reflected CRC-32 register, LSB first.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int b = 0; b < 8; b++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/eth_rx_crc32.sv
module eth_rx_crc32
    import eth_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       en,
    input  logic [7:0] data,
    output logic       crc_ok
);

    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_INIT;
        end else if (clear) begin
            crc_q <= CRC_INIT;
        end else if (en) begin
            crc_q <= crc_step(crc_q, data);
        end
    end

    assign crc_ok = (crc_q == CRC_RESIDUE);

endmodule

// File: rtl/eth_rx_fwd_ctrl.sv
module eth_rx_fwd_ctrl
    import eth_rx_pkg::*;
#(
    parameter int WDOG_LIMIT = 2048,
    parameter int HARD_LIMIT = 16384,
    parameter int CNT_W      = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             take,
    input  logic [7:0]       data,
    input  logic             strip_en,
    input  logic             wdog_en,
    output logic [CNT_W-1:0] cnt,
    output logic             fwd,
    output logic             cut
);

    localparam logic [CNT_W-1:0] LIM_SOFT = CNT_W'(WDOG_LIMIT);
    localparam logic [CNT_W-1:0] LIM_HARD = CNT_W'(HARD_LIMIT);

    logic [CNT_W-1:0] cnt_q;
    logic [15:0]      lt_q;
    logic             lt_known_q;
    logic [CNT_W-1:0] limit;
    logic             strip_active;
    logic             in_keep;

    assign limit        = wdog_en ? LIM_SOFT : LIM_HARD;
    assign cut          = (cnt_q >= limit);
    assign strip_active = strip_en && lt_known_q && (lt_q < TYPE_THRESHOLD);
    assign in_keep      = (32'(cnt_q) < (32'(lt_q) + 32'(HDR_BYTES)));
    assign fwd          = !cut && (!strip_active || in_keep);
    assign cnt          = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q      <= '0;
            lt_q       <= '0;
            lt_known_q <= 1'b0;
        end else if (take && !cut) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(LT_HI_IDX)) begin
                lt_q[15:8] <= data;
            end
            if (cnt_q == CNT_W'(LT_LO_IDX)) begin
                lt_q[7:0]  <= data;
                lt_known_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/eth_rx_out_stage.sv
module eth_rx_out_stage
    import eth_rx_pkg::*;
#(
    parameter int LEN_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [7:0]       push_data,
    input  logic             finish,
    input  rx_flags_t        fin_flags,
    input  logic [LEN_W-1:0] fin_len,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic             stat_valid,
    output rx_flags_t        stat_flags,
    output logic [LEN_W-1:0] stat_len
);

    logic       pend_v;
    logic [7:0] pend_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v     <= 1'b0;
            pend_d     <= '0;
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_last   <= 1'b0;
            stat_valid <= 1'b0;
            stat_flags <= '0;
            stat_len   <= '0;
        end else begin
            out_valid  <= 1'b0;
            out_last   <= 1'b0;
            stat_valid <= 1'b0;
            if (finish) begin
                out_valid  <= pend_v;
                out_data   <= pend_d;
                out_last   <= pend_v;
                pend_v     <= 1'b0;
                stat_valid <= 1'b1;
                stat_flags <= fin_flags;
                stat_len   <= fin_len;
            end else if (push) begin
                if (pend_v) begin
                    out_valid <= 1'b1;
                    out_data  <= pend_d;
                end
                pend_v <= 1'b1;
                pend_d <= push_data;
            end
        end
    end

endmodule

// File: rtl/eth_rx_framer.sv
module eth_rx_framer
    import eth_rx_pkg::*;
#(
    parameter int WDOG_LIMIT = 2048,
    parameter int HARD_LIMIT = 16384,
    parameter int TS_W       = 32,
    parameter int LEN_W      = $clog2(HARD_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_dv,
    input  logic [7:0]       rx_data,
    input  logic             cfg_strip_en,
    input  logic             cfg_wdog_en,
    input  logic             cfg_ts_en,
    input  logic [TS_W-1:0]  sys_time,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic             stat_valid,
    output logic             stat_crc_err,
    output logic             stat_wdog,
    output logic             stat_trunc,
    output logic [LEN_W-1:0] stat_len,
    output logic             stat_ts_valid,
    output logic [TS_W-1:0]  stat_ts
);

    rx_state_t        state_q, state_d;
    logic             sfd_hit;
    logic             take;
    logic             finish;
    logic             fin_cut;
    logic             crc_ok;
    logic             fwd;
    logic             cut;
    logic [LEN_W-1:0] cnt;
    rx_flags_t        fin_flags;
    rx_flags_t        stat_flags;
    logic [TS_W-1:0]  ts_q;
    logic             ts_v_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        sfd_hit = 1'b0;
        take    = 1'b0;
        finish  = 1'b0;
        fin_cut = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (rx_dv) begin
                    if (rx_data == SFD_BYTE) begin
                        state_d = ST_BODY;
                        sfd_hit = 1'b1;
                    end else if (rx_data == PRE_BYTE) begin
                        state_d = ST_PREAMBLE;
                    end else begin
                        state_d = ST_DISCARD;
                    end
                end
            end
            ST_PREAMBLE: begin
                if (!rx_dv) begin
                    state_d = ST_IDLE;
                end else if (rx_data == SFD_BYTE) begin
                    state_d = ST_BODY;
                    sfd_hit = 1'b1;
                end else if (rx_data != PRE_BYTE) begin
                    state_d = ST_DISCARD;
                end
            end
            ST_BODY: begin
                if (!rx_dv) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end else if (cut) begin
                    state_d = ST_DISCARD;
                    finish  = 1'b1;
                    fin_cut = 1'b1;
                end else begin
                    take = 1'b1;
                end
            end
            ST_DISCARD: begin
                if (!rx_dv) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Timestamp register: loaded only at the delimiter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q   <= '0;
            ts_v_q <= 1'b0;
        end else if (sfd_hit) begin
            ts_v_q <= cfg_ts_en;
            ts_q   <= cfg_ts_en ? sys_time : '0;
        end
    end

    eth_rx_crc32 u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (sfd_hit),
        .en     (take),
        .data   (rx_data),
        .crc_ok (crc_ok)
    );

    eth_rx_fwd_ctrl #(
        .WDOG_LIMIT (WDOG_LIMIT),
        .HARD_LIMIT (HARD_LIMIT),
        .CNT_W      (LEN_W)
    ) u_fwd (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sfd_hit),
        .take     (take),
        .data     (rx_data),
        .strip_en (cfg_strip_en),
        .wdog_en  (cfg_wdog_en),
        .cnt      (cnt),
        .fwd      (fwd),
        .cut      (cut)
    );

    always_comb begin
        fin_flags.crc_err = !crc_ok;
        fin_flags.wdog    = fin_cut;
        fin_flags.trunc   = !fin_cut && (32'(cnt) < 32'(MIN_FRAME_BYTES));
    end

    eth_rx_out_stage #(
        .LEN_W (LEN_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (take && fwd),
        .push_data  (rx_data),
        .finish     (finish),
        .fin_flags  (fin_flags),
        .fin_len    (cnt),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last),
        .stat_valid (stat_valid),
        .stat_flags (stat_flags),
        .stat_len   (stat_len)
    );

    assign stat_crc_err  = stat_flags.crc_err;
    assign stat_wdog     = stat_flags.wdog;
    assign stat_trunc    = stat_flags.trunc;
    assign stat_ts_valid = ts_v_q;
    assign stat_ts       = ts_q;

endmodule

// File: rtl/eth_rx_framer_chk.sv
module eth_rx_framer_chk
    import eth_rx_pkg::*;
#(
    parameter int WDOG_LIMIT = 2048,
    parameter int HARD_LIMIT = 16384,
    parameter int LEN_W      = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             out_last,
    input logic             stat_valid,
    input logic             stat_wdog,
    input logic             stat_trunc,
    input logic [LEN_W-1:0] stat_len
);

    a_r2_last_with_status: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (stat_valid && out_valid));

    a_r2_single_status: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> !stat_valid);

    a_r2_quiet_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> !out_valid);

    a_r5_cut_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_wdog) |->
            (32'(stat_len) == 32'(WDOG_LIMIT) || 32'(stat_len) == 32'(HARD_LIMIT)));

    a_r6_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> (32'(stat_len) <= 32'(HARD_LIMIT)));

    a_r9_trunc_short: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_trunc) |-> (32'(stat_len) < 32'(MIN_FRAME_BYTES) && !stat_wdog));

endmodule

bind eth_rx_framer eth_rx_framer_chk #(
    .WDOG_LIMIT (WDOG_LIMIT),
    .HARD_LIMIT (HARD_LIMIT),
    .LEN_W      (LEN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .out_last   (out_last),
    .stat_valid (stat_valid),
    .stat_wdog  (stat_wdog),
    .stat_trunc (stat_trunc),
    .stat_len   (stat_len)
);

// File: tb/tb_eth_rx_framer.sv
`timescale 1ns/1ps
module tb_eth_rx_framer;

    localparam int SOFT = 80;
    localparam int HARD = 160;
    localparam int TSW  = 32;
    localparam int LW   = $clog2(HARD + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           rx_dv = 1'b0;
    logic [7:0]     rx_data = '0;
    logic           cfg_strip_en = 1'b0;
    logic           cfg_wdog_en = 1'b1;
    logic           cfg_ts_en = 1'b0;
    logic [TSW-1:0] sys_time = '0;
    logic           out_valid, out_last, stat_valid;
    logic [7:0]     out_data;
    logic           stat_crc_err, stat_wdog, stat_trunc, stat_ts_valid;
    logic [LW-1:0]  stat_len;
    logic [TSW-1:0] stat_ts;

    always #2.5 clk = ~clk;

    eth_rx_framer #(.WDOG_LIMIT(SOFT), .HARD_LIMIT(HARD), .TS_W(TSW)) dut (
        .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_data(rx_data),
        .cfg_strip_en(cfg_strip_en), .cfg_wdog_en(cfg_wdog_en), .cfg_ts_en(cfg_ts_en),
        .sys_time(sys_time), .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .stat_valid(stat_valid), .stat_crc_err(stat_crc_err), .stat_wdog(stat_wdog),
        .stat_trunc(stat_trunc), .stat_len(stat_len), .stat_ts_valid(stat_ts_valid),
        .stat_ts(stat_ts)
    );

    int n_checks = 0;
    int n_fails  = 0;

    logic [7:0] frm [0:255];
    int         frm_n;
    logic [7:0] got [0:255];
    int         got_n;
    int         last_pos;
    int         stat_n;
    logic       s_crc, s_wd, s_tr, s_tsv;
    int         s_len;
    logic [31:0] s_ts;
    logic [31:0] exp_ts;
    int         frame_id = 0;

    always @(negedge clk) begin
        if (out_valid) begin
            if (out_last) last_pos = got_n;
            if (got_n < 256) got[got_n] = out_data;
            got_n = got_n + 1;
        end
        if (stat_valid) begin
            stat_n = stat_n + 1;
            s_crc  = stat_crc_err;
            s_wd   = stat_wdog;
            s_tr   = stat_trunc;
            s_len  = int'(stat_len);
            s_tsv  = stat_ts_valid;
            s_ts   = stat_ts;
        end
    end

    task automatic chk(input string tag, input longint act, input longint expv);
        n_checks++;
        if (act != expv) begin
            n_fails++;
            $display("FAIL %s frame %0d: actual %0d expected %0d", tag, frame_id, act, expv);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb = c[0] ^ frm[i][b];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c;
    endfunction

    task automatic build(input int lt, input int body_n, input bit add_fcs, input bit corrupt, input int seed);
        logic [31:0] f;
        for (int i = 0; i < body_n; i++) begin
            if (i == 12)      frm[i] = lt[15:8];
            else if (i == 13) frm[i] = lt[7:0];
            else if (i < 12)  frm[i] = 8'(i * 17 + seed);
            else              frm[i] = 8'(i * 7 + seed * 3);
        end
        frm_n = body_n;
        if (add_fcs) begin
            f = ~ref_crc(body_n);
            if (corrupt) f = f ^ 32'h0000_0100;
            frm[body_n]     = f[7:0];
            frm[body_n + 1] = f[15:8];
            frm[body_n + 2] = f[23:16];
            frm[body_n + 3] = f[31:24];
            frm_n = body_n + 4;
        end
    endtask

    task automatic clear_mon();
        got_n = 0; last_pos = -1; stat_n = 0;
    endtask

    task automatic send(input int n_pre, input bit strip, input bit wd, input bit ts);
        frame_id++;
        clear_mon();
        cfg_strip_en = strip; cfg_wdog_en = wd; cfg_ts_en = ts;
        for (int i = 0; i < n_pre; i++) begin
            @(negedge clk); rx_dv = 1'b1; rx_data = 8'h55; sys_time = sys_time + 1;
        end
        @(negedge clk); rx_dv = 1'b1; rx_data = 8'hD5;
        sys_time = 32'hC000_0000 + 32'(frame_id); exp_ts = sys_time;
        for (int i = 0; i < frm_n; i++) begin
            @(negedge clk); rx_dv = 1'b1; rx_data = frm[i]; sys_time = sys_time + 1;
        end
        @(negedge clk); rx_dv = 1'b0; rx_data = 8'h00;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_frame(input bit strip, input bit wd, input bit ts);
        int lim, acc, fwd_n, lt, bad;
        lim = wd ? SOFT : HARD;
        acc = (frm_n > lim) ? lim : frm_n;
        lt  = (frm_n >= 14) ? int'({frm[12], frm[13]}) : 32'hFFFF;
        fwd_n = acc;
        if (strip && acc >= 14 && lt < 32'h600 && acc > 14 + lt) fwd_n = 14 + lt;
        chk("R2 status count", stat_n, 1);
        chk((strip && lt < 32'h600) ? "R3 forwarded count" : "R4 forwarded count", got_n, fwd_n);
        bad = 0;
        for (int i = 0; i < fwd_n && i < got_n; i++) if (got[i] != frm[i]) bad++;
        chk("R1 byte mismatches", bad, 0);
        chk("R2 last position", last_pos, fwd_n - 1);
        chk("R7 crc error", s_crc, (ref_crc(acc) != 32'hDEBB20E3) ? 1 : 0);
        chk(wd ? "R5 watchdog flag" : "R6 watchdog flag", s_wd, (frm_n > lim) ? 1 : 0);
        chk("R9 length", s_len, acc);
        chk("R9 trunc", s_tr, (frm_n <= lim && acc < 18) ? 1 : 0);
        chk("R8 ts valid", s_tsv, ts);
        if (ts) chk("R8 ts value", s_ts, exp_ts);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        clear_mon();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset out_valid", out_valid, 0);
        chk("R2 reset stat_valid", stat_valid, 0);

        // R3: strip enabled, sweep length field across the pad boundary
        for (int lt = 0; lt <= 60; lt++) begin
            build(lt, 14 + ((lt < 46) ? 46 : lt), 1'b1, 1'b0, lt);
            send(lt % 8, 1'b1, 1'b1, 1'b1);
            check_frame(1'b1, 1'b1, 1'b1);
        end
        // R4: strip disabled, same frames forwarded whole
        for (int lt = 0; lt <= 60; lt += 4) begin
            build(lt, 14 + ((lt < 46) ? 46 : lt), 1'b1, 1'b0, lt + 5);
            send(7, 1'b0, 1'b1, 1'b0);
            check_frame(1'b0, 1'b1, 1'b0);
        end
        // R4: type values at and above the threshold with stripping on
        for (int p = 46; p <= 60; p++) begin
            build((p & 1) ? 16'h0800 : 16'h0600, 14 + p, 1'b1, 1'b0, p);
            send(3, 1'b1, 1'b1, 1'b1);
            check_frame(1'b1, 1'b1, 1'b1);
        end
        // R7: corrupted FCS, stripping on and off
        for (int k = 0; k < 4; k++) begin
            build(20 + k, 60, 1'b1, 1'b1, k);
            send(2, k[0], 1'b1, 1'b0);
            check_frame(k[0], 1'b1, 1'b0);
        end
        // R5: lengths around the configurable cutoff
        for (int n = SOFT - 4; n <= SOFT + 4; n++) begin
            build(16'h0800, n - 4, 1'b1, 1'b0, n);
            send(5, 1'b1, 1'b1, 1'b1);
            check_frame(1'b1, 1'b1, 1'b1);
        end
        // R6: lengths around the hard cutoff, watchdog disabled
        for (int n = HARD - 4; n <= HARD + 4; n++) begin
            build(16'h0800, n - 4, 1'b1, 1'b0, n);
            send(1, 1'b0, 1'b0, 1'b0);
            check_frame(1'b0, 1'b0, 1'b0);
        end
        // R9: short bursts across the truncation boundary
        for (int n = 0; n <= 20; n++) begin
            build(16'h0010, n, 1'b0, 1'b0, n);
            send(n % 3, 1'b1, 1'b1, 1'b1);
            check_frame(1'b1, 1'b1, 1'b1);
        end

        // R10: preamble-only burst
        frame_id++;
        clear_mon();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); rx_dv = 1'b1; rx_data = 8'h55;
        end
        @(negedge clk); rx_dv = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 status count", stat_n, 0);
        chk("R10 output count", got_n, 0);

        // R1: foreign byte before the delimiter discards the burst
        frame_id++;
        clear_mon();
        @(negedge clk); rx_dv = 1'b1; rx_data = 8'h55;
        @(negedge clk); rx_data = 8'h3C;
        @(negedge clk); rx_data = 8'hD5;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); rx_data = 8'(i + 1);
        end
        @(negedge clk); rx_dv = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 discard status count", stat_n, 0);
        chk("R1 discard output count", got_n, 0);

        // R1: a clean frame straight after the discard is received normally
        build(30, 60, 1'b1, 1'b0, 99);
        send(0, 1'b1, 1'b1, 1'b1);
        check_frame(1'b1, 1'b1, 1'b1);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule